// File: doc/BRIEF.md
# Dual-Section Presettable Decade Counter

The block is a four-bit decade counter split into two sections. A divide-by-two section holds the low output bit. A divide-by-five section holds the upper three bits as a value from 0 to 4. Each section has its own count input. A section advances when its input goes from high to low. Both count inputs are sampled on the system clock, so every edge is detected synchronously and the block has a single clock domain.

A two-bit cascade select picks one of three wirings of the sections:

- Independent: each section runs from its own input.
- BCD: the low bit's falling edge clocks the five section, so the output counts 0 to 9 in 8-4-2-1 code.
- Bi-quinary: the falling edge of the five section's top bit clocks the two section. The low bit then becomes a symmetric square wave at one tenth of the input rate.

An active-low clear and an active-low transparent preset act on the outputs at once, with no clock edge needed. The clear has priority over the preset, and the preset has priority over counting.

Top module: `dsc_top`

## Requirements
- R1: While `clear_n` is 0, `q` reads 0000 in the same cycle, whatever `preset_n`, `preset_val` and the count inputs do. After the clock edge the stored state is 0000.
- R2: While `clear_n` is 1 and `preset_n` is 0, `q` equals `preset_val` combinationally and follows any change on it. Count inputs have no effect. The value present at a clock edge is stored.
- R3: A fall on `tick2` toggles `q[0]` at the clock edge where `tick2` is first sampled low after a high sample. This applies in cascade modes 0 (independent) and 3, and in mode 1 (BCD). In modes 0 and 3 it does not move `q[3:1]`.
- R4: In modes 0 and 3, a fall on `tick5` advances `q[3:1]` through 0,1,2,3,4 and back to 0, and leaves `q[0]` unchanged.
- R5: In mode 1 (BCD), successive `tick2` falls make `q` count 0 to 9 and wrap to 0. When `q[0]` falls, the upper section advances in the same clock cycle. `tick5` is ignored.
- R6: In mode 2 (bi-quinary), successive `tick5` falls step the count n from 0 to 9. The output is `q[3:1]` = n mod 5 and `q[0]` = 1 when n is 5 or more. When `q[3]` falls, `q[0]` toggles in the same cycle. `tick2` is ignored.
- R7: In mode 2, `q[0]` is high for exactly 5 of every 10 consecutive counts.
- R8: A preset that puts 5, 6 or 7 on `q[3:1]` goes to 0 on the next count of the upper section. In mode 2 this fall of `q[3]` also toggles `q[0]`.
- R9: A count input that was sampled high only while clear or preset was active produces no count when it is sampled low after the release. The next fall after a fresh high sample counts normally.
- R10: A synchronous `rst` (active high) sets the stored state to 0000 and clears both edge detectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clear_n | input | 1 | Master clear, active low, highest priority |
| preset_n | input | 1 | Transparent preset, active low |
| preset_val | input | 4 | Preset value, bit 0 to the two section, bits 3..1 to the five section |
| cascade | input | 2 | 0/3 independent, 1 BCD, 2 bi-quinary |
| tick2 | input | 1 | Count input of the divide-by-two section |
| tick5 | input | 1 | Count input of the divide-by-five section |
| q | output | 4 | Counter outputs |

## Verification
A wrong state in either section shows on `q` right after the clock edge where the faulty count is taken, because the outputs read the stored state directly. A wrong cascade path shows in one of two ways. It can make a section stall. It can also make a section move in the wrong cycle, and that appears within a single input pulse, at the 1-to-2 step in BCD or the 4-to-5 step in bi-quinary. An edge detector that is not resynchronised shows as an extra count at the first clock edge after clear or preset is released.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int FIVE_MOD = 5;
    localparam int FIVE_W   = $clog2(FIVE_MOD);
    localparam int OUT_W    = FIVE_W + 1;

    typedef enum logic [1:0] {
        CASC_NONE = 2'd0,
        CASC_BCD  = 2'd1,
        CASC_BIQ  = 2'd2,
        CASC_ALT  = 2'd3
    } casc_e;

    typedef struct packed {
        logic [FIVE_W-1:0] hi;
        logic              lo;
    } count_t;

    function automatic logic [FIVE_W-1:0] five_next(input logic [FIVE_W-1:0] v);
        if (int'(v) >= FIVE_MOD - 1) return '0;
        return v + 1'b1;
    endfunction

    function automatic logic five_msb_drops(input logic [FIVE_W-1:0] v);
        logic [FIVE_W-1:0] n;
        n = five_next(v);
        return v[FIVE_W-1] & ~n[FIVE_W-1];
    endfunction

endpackage

// File: rtl/dsc_edge.sv
module dsc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev;
        always_ff @(posedge clk) begin
            if (rst) prev <= 1'b0;
            else     prev <= din[i] & ~hold;
        end
        assign fall[i] = prev & ~din[i];

        AST_NO_EDGE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
            $past(hold) |-> !fall[i]); // R9
    end
endmodule

// File: rtl/dsc_div2.sv
module dsc_div2 (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic ld_val,
    input  logic step,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= ld_val;
        else if (step) q <= ~q;
    end

    AST_TWO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> q != $past(q)); // R3
endmodule

// File: rtl/dsc_div5.sv
module dsc_div5
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [FIVE_W-1:0] ld_val,
    input  logic              step,
    output logic [FIVE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= ld_val;
        else if (step) q <= five_next(q);
    end

    AST_FIVE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> int'(q) < FIVE_MOD); // R8
endmodule

// File: rtl/dsc_top.sv
module dsc_top
    import dsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             preset_n,
    input  logic [OUT_W-1:0] preset_val,
    input  logic [1:0]       cascade,
    input  logic             tick2,
    input  logic             tick5,
    output logic [OUT_W-1:0] q
);
    casc_e  mode;
    count_t st;
    count_t ld;
    logic   override;
    logic [1:0] fall;
    logic   cas_from_lo;
    logic   cas_from_hi;
    logic   step2;
    logic   step5;

    assign mode     = casc_e'(cascade);
    assign override = ~clear_n | ~preset_n;
    assign ld       = clear_n ? count_t'(preset_val) : count_t'('0);

    dsc_edge #(.N(2)) u_edge (
        .clk (clk),
        .rst (rst),
        .hold(override),
        .din ({tick5, tick2}),
        .fall(fall)
    );

    // cascade sources come from current state, so no combinational loop forms
    assign cas_from_lo = st.lo & fall[0];
    assign cas_from_hi = five_msb_drops(st.hi) & fall[1];

    always_comb begin
        step2 = fall[0];
        step5 = fall[1];
        case (mode)
            CASC_BCD: step5 = cas_from_lo;
            CASC_BIQ: step2 = cas_from_hi;
            default: ;
        endcase
    end

    dsc_div2 u_two (
        .clk   (clk),
        .rst   (rst),
        .load  (override),
        .ld_val(ld.lo),
        .step  (step2),
        .q     (st.lo)
    );

    dsc_div5 u_five (
        .clk   (clk),
        .rst   (rst),
        .load  (override),
        .ld_val(ld.hi),
        .step  (step5),
        .q     (st.hi)
    );

    always_comb begin
        if (!clear_n)       q = '0;
        else if (!preset_n) q = preset_val;
        else                q = st;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> st == count_t'('0)); // R1
    AST_PRESET_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !preset_n) |=> st == count_t'($past(preset_val))); // R2
    AST_BCD_IGNORES_TICK5: assert property (@(posedge clk) disable iff (rst)
        (mode == CASC_BCD && !override && !fall[0]) |=> $stable(st)); // R5
    AST_BIQ_IGNORES_TICK2: assert property (@(posedge clk) disable iff (rst)
        (mode == CASC_BIQ && !override && !fall[1]) |=> $stable(st)); // R6
endmodule

// File: tb/dsc_top_bench.sv
module dsc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       clear_n, preset_n, tick2, tick5;
    logic [3:0] preset_val;
    logic [1:0] cascade;
    logic [3:0] q;
    int checks = 0;
    int errors = 0;

    dsc_top u_dsc_top (
        .clk(clk), .rst(rst), .clear_n(clear_n), .preset_n(preset_n),
        .preset_val(preset_val), .cascade(cascade), .tick2(tick2),
        .tick5(tick5), .q(q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // fields: mode, clear_n, preset_n, preset_val, tick2, tick5, expected q, requirement
    localparam int NV = 15;
    localparam logic [17:0] VEC [0:NV-1] = '{
        {2'd0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 4'h0, 4'd1},  // R1
        {2'd0, 1'b1, 1'b0, 4'hA, 1'b0, 1'b0, 4'hA, 4'd2},  // R2
        {2'd0, 1'b1, 1'b0, 4'h5, 1'b1, 1'b1, 4'h5, 4'd2},  // R2
        {2'd0, 1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 4'h5, 4'd2},  // R2 ticks ignored
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h5, 4'd2},
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 4'h5, 4'd3},
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h4, 4'd3},  // R3
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'h4, 4'd4},
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h6, 4'd4},  // R4
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 4'h6, 4'd4},
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h9, 4'd4},  // R4 and R3 together
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'h9, 4'd4},
        {2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h1, 4'd4},  // R4 wrap, no cascade
        {2'd3, 1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 4'h1, 4'd3},
        {2'd3, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, 4'd3}   // R3 mode 3
    };

    task automatic check(input logic [3:0] exp, input string tag);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%h expected %h", tag, q, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic c, input logic l,
                        input logic [3:0] p, input logic a, input logic b,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        cascade = m; clear_n = c; preset_n = l; preset_val = p;
        tick2 = a; tick5 = b;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    task automatic zero_state(input logic [1:0] m);
        step(m, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, "R1");
        step(m, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, "R1");
    endtask

    initial begin
        int n;
        int highs;
        logic [3:0] e;
        rst = 1'b1; clear_n = 1'b1; preset_n = 1'b1; preset_val = '0;
        cascade = '0; tick2 = 1'b0; tick5 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(4'h0, "R10 reset state");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:16], VEC[i][15], VEC[i][14], VEC[i][13:10],
                 VEC[i][9], VEC[i][8], VEC[i][7:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
        end

        // R1 clear beats preset
        step(2'd0, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, "R1 over preset");

        // R2 transparency between clock edges
        @(negedge clk);
        clear_n = 1'b1; preset_n = 1'b0; preset_val = 4'h3;
        #1 check(4'h3, "R2 transparent");
        preset_val = 4'hC;
        #1 check(4'hC, "R2 follows change");

        // R5 BCD counting, tick5 toggled against the pulse
        zero_state(2'd1);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step(2'd1, 1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 4'(n), "R5 high phase");
            n = (n + 1) % 10;
            step(2'd1, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'(n), "R5");
        end

        // R6 / R7 bi-quinary counting, tick2 toggled
        zero_state(2'd2);
        n = 0; highs = 0;
        for (int i = 0; i < 20; i++) begin
            step(2'd2, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'h0 | q, "R6 high phase");
            n = (n + 1) % 10;
            e = {3'(n % 5), (n >= 5) ? 1'b1 : 1'b0};
            step(2'd2, 1'b1, 1'b1, 4'h0, 1'b1, 1'b0, e, "R6");
            if (i >= 10 && q[0]) highs++;
        end
        checks++;
        if (highs != 5) begin
            errors++;
            $display("FAIL R7: high counts=%0d expected 5", highs);
        end

        // R8 out-of-range recovery
        step(2'd2, 1'b1, 1'b0, 4'hA, 1'b0, 1'b0, 4'hA, "R8 preset 5");
        step(2'd2, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'hA, "R8 hold");
        step(2'd2, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h1, "R8 biq wrap");
        step(2'd0, 1'b1, 1'b0, 4'hE, 1'b0, 1'b0, 4'hE, "R8 preset 7");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'hE, "R8 hold");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, "R8 indep wrap");

        // R9 resync after preset and clear
        step(2'd0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 4'h0, "R9 preset tick high");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, "R9 no count");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b1, 1'b0, 4'h0, "R9 fresh high");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h1, "R9 counts");
        step(2'd0, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 4'h0, "R9 clear tick high");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0, "R9 no count");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 4'h0, "R9 fresh high");
        step(2'd0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 4'h2, "R9 counts");

        // R10 reset mid-run
        step(2'd0, 1'b1, 1'b0, 4'h7, 1'b0, 1'b0, 4'h7, "R10 preload");
        @(negedge clk);
        preset_n = 1'b1; rst = 1'b1;
        @(posedge clk);
        #1 check(4'h0, "R10 mid-run reset");
        @(negedge clk);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule